// File: doc/BRIEF.md
# Virtual-Output-Queue Slot Scheduler

This block decides, once per cell slot, which inputs of an N-by-N input-queued crossbar may send and to which outputs. It keeps a matrix of packet counts in which entry (i,j) is the number of packets waiting at input i for output j. Each input reports at most one newly queued packet per clock, giving the output it is bound for, and that entry grows by one.

On every slot strobe the block builds a greedy maximal matching from the counts. An input may send a packet that is not at the head of its queue, so one busy output never stalls traffic for other outputs. The result is registered as one input index plus a valid bit per output, which steers that output's crossbar multiplexer. Each granted count drops by one. A maximal matching is never smaller than half of a maximum matching for the same counts.

Top module: `voq_slot_sched`

## Requirements
- R1: While arr_valid[i] is high in a clock cycle, entry (i, arr_dst[i]) grows by one, where arr_dst[i] is the IDX_W-bit field at bits i*IDX_W upward. The increment is subject to R6 and R7.
- R2: Within one slot, no input index appears in more than one valid grant, and each output carries at most one grant.
- R3: Output j grants input i only if entry (i,j) was nonzero when the slot decision was taken.
- R4: After a decision, no nonzero entry remains whose input row has no grant and whose output column has no grant.
- R5: Outputs are visited starting at a start index that is 0 after reset and advances by one, modulo N, on every slot strobe. Each output has a pointer, 0 after reset. The output takes the first free input with a nonzero entry, searching circularly from its pointer. After a grant, that pointer moves to one past the granted input.
- R6: If an arrival and a grant fall on the same entry in the same cycle, the entry is unchanged.
- R7: Counts saturate at 2^CNT_W-1. An arrival that would exceed this is dropped, and count_ovf is high for exactly the one cycle after that clock edge.
- R8: Reset clears all grants and counts. grant_valid and grant_src change only at the clock edge where slot_tick was high, and they hold their values in between.
- R9: An arrival presented in the same cycle as slot_tick is not eligible for that slot's decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_tick | input | 1 | Slot boundary strobe; a decision is taken in this cycle |
| arr_valid | input | N | Per-input arrival strobe |
| arr_dst | input | N*IDX_W | Per-input destination output index, field i at bits i*IDX_W |
| grant_valid | output | N | Per-output grant present |
| grant_src | output | N*IDX_W | Per-output granted input index, field j at bits j*IDX_W |
| count_ovf | output | 1 | One-cycle pulse: an arrival was dropped at saturation |

## Verification
A count that is wrong inside the block shows up as a grant that is missing or extra. It appears at the first slot in which the pointers reach that entry, or at the latest while the matrix drains. A corrupted pointer changes which input wins at the very next slot. So the full grant vector is compared at every slot against a model that keeps its own counts and pointers. Row and column uniqueness and maximality are also checked on the observed grants directly, so that errors in the ordering are told apart from a matching that is not legal.

// File: rtl/voq_pkg.sv
package voq_pkg;
  function automatic int wrap_inc(input int v, input int n);
    return (v + 1) % n;
  endfunction
endpackage

// File: rtl/voq_backlog.sv
module voq_backlog #(
  parameter int N     = 4,
  parameter int CNT_W = 4,
  parameter int IDX_W = $clog2(N)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N-1:0]       arr_valid,
  input  logic [N*IDX_W-1:0] arr_dst,
  input  logic [N*N-1:0]     dec,
  output logic [N*N-1:0]     nz,
  output logic               ovf_pulse
);
  localparam int E = N * N;
  localparam logic [CNT_W-1:0] MAXC = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q [E];
  logic [E-1:0] inc, sat_hit;

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      localparam int EI = i * N + j;
      assign inc[EI]     = arr_valid[i] && (arr_dst[i*IDX_W +: IDX_W] == IDX_W'(j));
      assign sat_hit[EI] = inc[EI] && !dec[EI] && (cnt_q[EI] == MAXC);
      assign nz[EI]      = (cnt_q[EI] != '0);

      always_ff @(posedge clk) begin
        if (rst) cnt_q[EI] <= '0;
        else if (inc[EI] && !dec[EI] && cnt_q[EI] != MAXC) cnt_q[EI] <= cnt_q[EI] + 1'b1;
        else if (!inc[EI] && dec[EI]) cnt_q[EI] <= cnt_q[EI] - 1'b1;
      end

      p_dec_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
        dec[EI] |-> cnt_q[EI] != '0);
      p_net_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (inc[EI] && dec[EI]) |=> $stable(cnt_q[EI]));
      p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        (cnt_q[EI] == MAXC && !dec[EI]) |=> cnt_q[EI] == MAXC);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ovf_pulse <= 1'b0;
    else     ovf_pulse <= |sat_hit;
  end
endmodule

// File: rtl/voq_greedy_match.sv
module voq_greedy_match #(
  parameter int N     = 4,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N*N-1:0]     nz,
  input  logic [IDX_W-1:0]   out_start,
  input  logic [N*IDX_W-1:0] in_ptr,
  output logic [N-1:0]       m_valid,
  output logic [N*IDX_W-1:0] m_src
);
  logic [N-1:0] taken;

  always_comb begin
    taken   = '0;
    m_valid = '0;
    m_src   = '0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = (int'(out_start) + k) % N;
      for (int m = 0; m < N; m++) begin
        int i;
        i = (int'(in_ptr[j*IDX_W +: IDX_W]) + m) % N;
        if (!m_valid[j] && !taken[i] && nz[i*N + j]) begin
          m_valid[j]                = 1'b1;
          m_src[j*IDX_W +: IDX_W]   = IDX_W'(i);
          taken[i]                  = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/voq_slot_sched.sv
module voq_slot_sched #(
  parameter int N     = 4,
  parameter int CNT_W = 4,
  parameter int IDX_W = $clog2(N)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               slot_tick,
  input  logic [N-1:0]       arr_valid,
  input  logic [N*IDX_W-1:0] arr_dst,
  output logic [N-1:0]       grant_valid,
  output logic [N*IDX_W-1:0] grant_src,
  output logic               count_ovf
);
  import voq_pkg::*;

  logic [N*N-1:0]     nz, dec;
  logic [N-1:0]       m_valid;
  logic [N*IDX_W-1:0] m_src;
  logic [IDX_W-1:0]   out_ptr;
  logic [N*IDX_W-1:0] in_ptr;

  voq_backlog #(.N(N), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_backlog (
    .clk(clk), .rst(rst), .arr_valid(arr_valid), .arr_dst(arr_dst),
    .dec(dec), .nz(nz), .ovf_pulse(count_ovf)
  );

  voq_greedy_match #(.N(N), .IDX_W(IDX_W)) u_match (
    .nz(nz), .out_start(out_ptr), .in_ptr(in_ptr),
    .m_valid(m_valid), .m_src(m_src)
  );

  for (genvar i = 0; i < N; i++) begin : g_dec_row
    for (genvar j = 0; j < N; j++) begin : g_dec_col
      assign dec[i*N + j] = slot_tick && m_valid[j] &&
                            (m_src[j*IDX_W +: IDX_W] == IDX_W'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_valid <= '0;
      grant_src   <= '0;
      out_ptr     <= '0;
      in_ptr      <= '0;
    end else if (slot_tick) begin
      grant_valid <= m_valid;
      grant_src   <= m_src;
      out_ptr     <= IDX_W'(wrap_inc(int'(out_ptr), N));
      for (int j = 0; j < N; j++)
        if (m_valid[j])
          in_ptr[j*IDX_W +: IDX_W] <= IDX_W'(wrap_inc(int'(m_src[j*IDX_W +: IDX_W]), N));
    end
  end

  // Checking support: which inputs the fresh decision and the held grants use.
  logic [N-1:0] in_used;
  logic [N-1:0] held_hits [N];
  always_comb begin
    in_used = '0;
    for (int i = 0; i < N; i++) begin
      held_hits[i] = '0;
      for (int j = 0; j < N; j++) begin
        if (m_valid[j] && m_src[j*IDX_W +: IDX_W] == IDX_W'(i)) in_used[i] = 1'b1;
        held_hits[i][j] = grant_valid[j] && (grant_src[j*IDX_W +: IDX_W] == IDX_W'(i));
      end
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !slot_tick |=> ($stable(grant_valid) && $stable(grant_src)));

  for (genvar i = 0; i < N; i++) begin : g_chk_in
    p_row_unique_r2: assert property (@(posedge clk) disable iff (rst)
      $onehot0(held_hits[i]));
    for (genvar j = 0; j < N; j++) begin : g_chk_pair
      p_maximal_r4: assert property (@(posedge clk) disable iff (rst)
        (slot_tick && nz[i*N + j]) |-> (m_valid[j] || in_used[i]));
    end
  end

  for (genvar j = 0; j < N; j++) begin : g_chk_out
    p_grant_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
      (slot_tick && m_valid[j]) |-> nz[int'(m_src[j*IDX_W +: IDX_W])*N + j]);
  end
endmodule

// File: tb/sim_voq_slot_sched.sv
module sim_voq_slot_sched;
  localparam int N     = 4;
  localparam int CNT_W = 4;
  localparam int IDX_W = $clog2(N);
  localparam int MAXC  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slot_tick = 1'b0;
  logic [N-1:0] arr_valid = '0;
  logic [N*IDX_W-1:0] arr_dst = '0;
  logic [N-1:0] grant_valid;
  logic [N*IDX_W-1:0] grant_src;
  logic count_ovf;

  voq_slot_sched #(.N(N), .CNT_W(CNT_W), .IDX_W(IDX_W)) u0 (
    .clk(clk), .rst(rst), .slot_tick(slot_tick), .arr_valid(arr_valid),
    .arr_dst(arr_dst), .grant_valid(grant_valid), .grant_src(grant_src),
    .count_ovf(count_ovf)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;
  int cnt_m [N][N];
  int pre_m [N][N];
  int iptr_m [N];
  int optr_m = 0;
  bit e_gv [N];
  int e_gs [N];
  logic [N-1:0] prev_gv;
  logic [N*IDX_W-1:0] prev_gs;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One clock: drive at a falling edge, update model, check at next falling edge.
  task automatic do_cycle(input bit tick, input logic [N-1:0] av, input logic [N*IDX_W-1:0] ad);
    bit taken [N];
    bit e_ovf;
    bit granted;
    int d;
    e_ovf = 0;
    for (int i = 0; i < N; i++) begin
      taken[i] = 0;
      for (int j = 0; j < N; j++) pre_m[i][j] = cnt_m[i][j];
    end
    for (int j = 0; j < N; j++) begin e_gv[j] = 0; e_gs[j] = 0; end
    if (tick) begin
      for (int k = 0; k < N; k++) begin
        int j;
        j = (optr_m + k) % N;
        for (int m = 0; m < N; m++) begin
          int i;
          i = (iptr_m[j] + m) % N;
          if (!e_gv[j] && !taken[i] && pre_m[i][j] != 0) begin
            e_gv[j] = 1; e_gs[j] = i; taken[i] = 1;
          end
        end
      end
      for (int j = 0; j < N; j++)
        if (e_gv[j]) begin
          cnt_m[e_gs[j]][j]--;
          iptr_m[j] = (e_gs[j] + 1) % N;
        end
      optr_m = (optr_m + 1) % N;
    end
    for (int i = 0; i < N; i++)
      if (av[i]) begin
        d = int'(ad[i*IDX_W +: IDX_W]);
        granted = tick && e_gv[d] && e_gs[d] == i;
        if (granted) cnt_m[i][d]++;
        else if (pre_m[i][d] < MAXC) cnt_m[i][d]++;
        else e_ovf = 1;
      end
    prev_gv = grant_valid;
    prev_gs = grant_src;
    slot_tick = tick; arr_valid = av; arr_dst = ad;
    @(negedge clk);
    slot_tick = 0; arr_valid = '0;
    check(count_ovf == e_ovf, "R7", "count_ovf", count_ovf, e_ovf);
    if (tick) begin
      bit used_in [N];
      for (int i = 0; i < N; i++) used_in[i] = 0;
      for (int j = 0; j < N; j++) begin
        int s;
        s = int'(grant_src[j*IDX_W +: IDX_W]);
        check(grant_valid[j] == e_gv[j], "R5", "grant_valid", grant_valid[j], e_gv[j]);
        if (grant_valid[j] && e_gv[j])
          check(s == e_gs[j], "R5", "grant_src", s, e_gs[j]);
        if (grant_valid[j]) begin
          check(!used_in[s], "R2", "input granted twice", s, -1);
          used_in[s] = 1;
          check(pre_m[s][j] != 0, "R3", "grant on empty entry", pre_m[s][j], 1);
        end
      end
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          if (pre_m[i][j] != 0 && !used_in[i] && !grant_valid[j])
            check(0, "R4", "unmatched nonzero pair", i*N + j, -1);
    end else begin
      check(grant_valid == prev_gv && grant_src == prev_gs, "R8", "grants held",
            int'(grant_valid), int'(prev_gv));
    end
  endtask

  initial begin
    #1500000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    for (int i = 0; i < N; i++) begin
      iptr_m[i] = 0;
      for (int j = 0; j < N; j++) cnt_m[i][j] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    check(grant_valid == '0, "R8", "reset grant_valid", int'(grant_valid), 0);
    check(count_ovf == 1'b0, "R8", "reset count_ovf", count_ovf, 0);

    // R9: arrival in the tick cycle must not be granted in that slot
    do_cycle(1'b1, 4'b0100, 8'b00_01_00_00);
    check(grant_valid == '0, "R9", "same-cycle arrival granted", int'(grant_valid), 0);
    do_cycle(1'b1, '0, '0);
    check(grant_valid[1] && grant_src[1*IDX_W +: IDX_W] == 2, "R1", "queued arrival granted",
          int'(grant_valid), 2);

    // R6: one packet at (3,0), tick with a new arrival on the same entry
    do_cycle(1'b0, 4'b1000, 8'b00_00_00_00);
    do_cycle(1'b1, 4'b1000, 8'b00_00_00_00);
    check(cnt_m[3][0] == 1, "R6", "model net zero", cnt_m[3][0], 1);
    do_cycle(1'b1, '0, '0);
    do_cycle(1'b1, '0, '0);
    check(grant_valid == '0, "R6", "entry drained after one more grant", int'(grant_valid), 0);

    // R7: flood (0,2) past saturation without ticks
    for (int n = 0; n < MAXC + 4; n++) do_cycle(1'b0, 4'b0001, 8'b00_00_00_10);
    // R5/R4: all inputs hit all outputs (contention), then a hot spot
    for (int n = 0; n < 8; n++) do_cycle(1'b0, 4'b1111, IDX_W*N'(n % 4) | 8'b11_10_01_00);
    for (int n = 0; n < 6; n++) do_cycle(1'b1, 4'b1111, 8'b01_01_01_01);

    // Constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [N-1:0] av;
      logic [N*IDX_W-1:0] ad;
      av = N'($urandom);
      ad = (N*IDX_W)'($urandom);
      do_cycle(($urandom % 3) == 0, av, ad);
    end
    // Drain: every queued packet must leave (R1 bookkeeping)
    for (int n = 0; n < 400; n++) do_cycle(1'b1, '0, '0);
    begin
      int tot;
      tot = 0;
      for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) tot += cnt_m[i][j];
      check(tot == 0, "R1", "model drained", tot, 0);
      check(grant_valid == '0, "R1", "no grants once drained", int'(grant_valid), 0);
    end

    // R8: reset clears state mid-traffic
    do_cycle(1'b0, 4'b1111, 8'b00_01_10_11);
    rst = 1;
    @(negedge clk);
    rst = 0;
    check(grant_valid == '0, "R8", "grants after reset", int'(grant_valid), 0);
    for (int i = 0; i < N; i++) begin
      iptr_m[i] = 0;
      for (int j = 0; j < N; j++) cnt_m[i][j] = 0;
    end
    optr_m = 0;
    do_cycle(1'b1, '0, '0);
    check(grant_valid == '0, "R8", "counts cleared by reset", int'(grant_valid), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule